// File: doc/BRIEF.md
# Bit-Serial GF(2^128) Group Multiplier

This block runs the hash-field multiply that authenticated-encryption modes use on a vector register group. The block treats each run of four 32-bit elements as one 128-bit group. For every group in the active range, it reads the accumulator operand Y from the destination register and the key operand H from the source register. It forms their product in GF(2^128) and writes the result back over the destination group. The destination register is therefore both an input and an output.

The multiply is bit-serial and handles one multiplier bit per clock. Each byte of both operands has its bit order reversed before use. The product bytes are reversed the same way before the write. The multiply walks Y from its least significant bit and shifts H left once per bit. When a one leaves the top of H, the block folds it back in with the constant 0x87. After the active groups, the block can fill the tail elements with all ones. It then reports completion and asks the caller to clear the vector start index.

Top module: `gfm_group_mult`

## Requirements
- R1: A start pulse seen while idle is accepted only when `sewCode` equals 2 (32-bit elements) and `vstart` is a multiple of 4. Otherwise `reject` is high for one cycle in the cycle after the start, and `busy`, `rdEn` and `wrEn` stay low.
- R2: Groups are processed in ascending order, from index vstart/4 up to but not including vl/4. Each group takes 130 cycles. The first is one read cycle with `rdEn` high and `rdIdx` set to the group. Then come 128 compute cycles, and then one write cycle with `wrIdx` set to the group and all four bits of `wrElemEn` set.
- R3: The group layout places bits [63:0] in the low half, and element e of the group occupies bits 32e+31..32e. The product is formed in four steps:
  - Bit-reverse every byte of Y and H.
  - For j = 0..127, XOR H into Z when bit j of Y is set, then shift H left one place. If the bit shifted out of position 127 was a one, XOR 0x87 into the low byte of H.
  - Bit-reverse every byte of Z.
  - Write the result as `wrData`.
- R4: Z starts at zero for every group, and no state carries from one group to the next. Two groups with equal operands produce equal products.
- R5: Each product is written to the same group index it was read from.
- R6: If vstart/4 is not less than vl/4, no group is read and no product is written. The run still ends normally.
- R7: When `tailAgn` is high and `vl` is less than `totalElems`, the block performs tail writes after the products. `totalElems` must be a multiple of 4 and no smaller than `vl`. There is one write per group, from vl/4 up to totalElems/4-1. Each write has `wrData` all ones, and bit e of `wrElemEn` is set exactly when 4*group+e is at least `vl`. When `tailAgn` is low, or `vl` equals `totalElems`, there are no tail writes.
- R8: `busy` is high from the cycle after an accepted start through the last cycle of the run. That last cycle follows the final write, or the empty read cycle. In that cycle `done` and `vstartClr` are both high. Both are low at every other time, and `busy` is low after it.
- R9: A start pulse while `busy` is high is ignored, and the run in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation |
| sewCode | input | 3 | Element width code (2 = 32 bits) |
| vl | input | CNT_W | Active element count |
| vstart | input | CNT_W | First element to process |
| tailAgn | input | 1 | Fill tail elements with ones |
| totalElems | input | CNT_W | Element count of the register group |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| reject | output | 1 | One-cycle pulse for an illegal start |
| vstartClr | output | 1 | Request to reset the start index to zero |
| rdEn | output | 1 | Group read strobe |
| rdIdx | output | CNT_W-2 | Group index to read |
| rdY | input | 128 | Destination group (Y) at `rdIdx`, same cycle |
| rdH | input | 128 | Source group (H) at `rdIdx`, same cycle |
| wrEn | output | 1 | Group write strobe |
| wrIdx | output | CNT_W-2 | Group index to write |
| wrElemEn | output | 4 | Per-element write enable |
| wrData | output | 128 | Write data |

## Verification
The bench targets the reduction edge with a directed pair whose single product step pushes a one out of bit 127. A design that dropped the fold, or put 0x87 on the wrong side of the byte reversal, would write something other than 0xE1 in the low byte. An identity pair, with 0x80 in Y's lowest byte, must return H unchanged, which catches a wrong bit scan order or byte reversal. Ranges where vl is not a multiple of four, and empty ranges where vstart lies at or past vl, test the partial tail mask. A design that computed that mask from the group boundary would overwrite the live elements below vl. A second start during a run would show up as an extra read, or as a `busy` that stayed high past `done`.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_MUL,
    ST_WRITE,
    ST_TAIL,
    ST_DONE
  } gfmState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } dpStrobe_t;

  localparam logic [2:0] SEW_CODE_32 = 3'd2;
endpackage

// File: rtl/gfm_datapath.sv
module gfm_datapath
  import gfm_pkg::*;
#(
  parameter int          GRP_W    = 128,
  parameter logic [7:0]  RED_POLY = 8'h87
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [GRP_W-1:0] opY,
  input  logic [GRP_W-1:0] opH,
  output logic [GRP_W-1:0] product
);
  localparam int NBYTES = GRP_W / 8;
  localparam logic [GRP_W-1:0] RED_MASK = GRP_W'(RED_POLY);

  logic [GRP_W-1:0] yRev, hRev;
  logic [GRP_W-1:0] yQ, hQ, zQ;

  // per-byte bit reversal on entry and exit
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign yRev[8*b+i]    = opY[8*b+7-i];
      assign hRev[8*b+i]    = opH[8*b+7-i];
      assign product[8*b+i] = zQ[8*b+7-i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      yQ <= '0;
      hQ <= '0;
      zQ <= '0;
    end else if (strb.load) begin
      yQ <= yRev;
      hQ <= hRev;
      zQ <= '0;
    end else if (strb.step) begin
      if (yQ[0]) zQ <= zQ ^ hQ;
      yQ <= yQ >> 1;
      hQ <= {hQ[GRP_W-2:0], 1'b0} ^ (hQ[GRP_W-1] ? RED_MASK : '0);
    end
  end

  // R4
  fresh_product_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (zQ == '0));

  // R3
  load_step_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load && strb.step));
endmodule

// File: rtl/gfm_ctrl.sv
module gfm_ctrl
  import gfm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int GRP_W = 128,
  parameter int EPG   = 4,
  parameter int GI_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       sewCode,
  input  logic [CNT_W-1:0] vl,
  input  logic [CNT_W-1:0] vstart,
  input  logic             tailAgn,
  input  logic [CNT_W-1:0] totalElems,
  output dpStrobe_t        strb,
  output logic             busy,
  output logic             done,
  output logic             reject,
  output logic             vstartClr,
  output logic             rdEn,
  output logic [GI_W-1:0]  rdIdx,
  output logic             wrEn,
  output logic [GI_W-1:0]  wrIdx,
  output logic [EPG-1:0]   wrElemEn,
  output logic             wrFill
);
  localparam int STEP_W = $clog2(GRP_W);
  localparam int EPG_W  = $clog2(EPG);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(GRP_W - 1);

  gfmState_e         stateQ;
  logic [GI_W-1:0]   grpQ, endGrpQ, totGrpQ;
  logic [CNT_W-1:0]  vlQ, totQ;
  logic              taQ, rejectQ;
  logic [STEP_W-1:0] stepQ;

  logic           startOk, haveGrp, tailNeeded, moreTail;
  logic [EPG-1:0] tailMask;

  assign startOk    = (sewCode == SEW_CODE_32) && (vstart[EPG_W-1:0] == '0);
  assign haveGrp    = grpQ < endGrpQ;
  assign tailNeeded = taQ && (vlQ < totQ);
  assign moreTail   = ({1'b0, grpQ} + 1'b1) < {1'b0, totGrpQ};

  for (genvar e = 0; e < EPG; e++) begin : g_mask
    assign tailMask[e] = {grpQ, EPG_W'(e)} >= vlQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      grpQ    <= '0;
      endGrpQ <= '0;
      totGrpQ <= '0;
      vlQ     <= '0;
      totQ    <= '0;
      taQ     <= 1'b0;
      stepQ   <= '0;
      rejectQ <= 1'b0;
    end else begin
      rejectQ <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            if (startOk) begin
              stateQ  <= ST_LOAD;
              grpQ    <= GI_W'(vstart >> EPG_W);
              endGrpQ <= GI_W'(vl >> EPG_W);
              totGrpQ <= GI_W'(totalElems >> EPG_W);
              vlQ     <= vl;
              totQ    <= totalElems;
              taQ     <= tailAgn;
            end else begin
              rejectQ <= 1'b1;
            end
          end
        end
        ST_LOAD: begin
          if (haveGrp) begin
            stateQ <= ST_MUL;
            stepQ  <= '0;
          end else begin
            grpQ   <= endGrpQ;
            stateQ <= tailNeeded ? ST_TAIL : ST_DONE;
          end
        end
        ST_MUL: begin
          stepQ <= stepQ + 1'b1;
          if (stepQ == LAST_STEP) stateQ <= ST_WRITE;
        end
        ST_WRITE: begin
          grpQ   <= grpQ + 1'b1;
          stateQ <= ST_LOAD;
        end
        ST_TAIL: begin
          if (moreTail) grpQ <= grpQ + 1'b1;
          else stateQ <= ST_DONE;
        end
        ST_DONE: stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb      = '0;
    rdEn      = 1'b0;
    wrEn      = 1'b0;
    wrFill    = 1'b0;
    wrElemEn  = '0;
    done      = 1'b0;
    vstartClr = 1'b0;
    case (stateQ)
      ST_LOAD: begin
        rdEn      = haveGrp;
        strb.load = haveGrp;
      end
      ST_MUL: strb.step = 1'b1;
      ST_WRITE: begin
        wrEn     = 1'b1;
        wrElemEn = '1;
      end
      ST_TAIL: begin
        wrEn     = 1'b1;
        wrFill   = 1'b1;
        wrElemEn = tailMask;
      end
      ST_DONE: begin
        done      = 1'b1;
        vstartClr = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy   = stateQ != ST_IDLE;
  assign reject = rejectQ;
  assign rdIdx  = grpQ;
  assign wrIdx  = grpQ;

  // R1
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reject |-> !busy);

  // R8
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R2
  read_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> !rdEn && busy);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
endmodule

// File: rtl/gfm_group_mult.sv
module gfm_group_mult
  import gfm_pkg::*;
#(
  parameter int         CNT_W    = 8,
  parameter int         ELEM_W   = 32,
  parameter int         GRP_W    = 128,
  parameter logic [7:0] RED_POLY = 8'h87,
  localparam int        EPG      = GRP_W / ELEM_W,
  localparam int        GI_W     = CNT_W - $clog2(EPG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       sewCode,
  input  logic [CNT_W-1:0] vl,
  input  logic [CNT_W-1:0] vstart,
  input  logic             tailAgn,
  input  logic [CNT_W-1:0] totalElems,
  output logic             busy,
  output logic             done,
  output logic             reject,
  output logic             vstartClr,
  output logic             rdEn,
  output logic [GI_W-1:0]  rdIdx,
  input  logic [GRP_W-1:0] rdY,
  input  logic [GRP_W-1:0] rdH,
  output logic             wrEn,
  output logic [GI_W-1:0]  wrIdx,
  output logic [EPG-1:0]   wrElemEn,
  output logic [GRP_W-1:0] wrData
);
  dpStrobe_t        strb;
  logic             wrFill;
  logic [GRP_W-1:0] product;

  gfm_ctrl #(
    .CNT_W(CNT_W), .GRP_W(GRP_W), .EPG(EPG), .GI_W(GI_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sewCode(sewCode), .vl(vl),
    .vstart(vstart), .tailAgn(tailAgn), .totalElems(totalElems),
    .strb(strb), .busy(busy), .done(done), .reject(reject),
    .vstartClr(vstartClr), .rdEn(rdEn), .rdIdx(rdIdx), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrElemEn(wrElemEn), .wrFill(wrFill)
  );

  gfm_datapath #(
    .GRP_W(GRP_W), .RED_POLY(RED_POLY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opY(rdY), .opH(rdH),
    .product(product)
  );

  assign wrData = wrFill ? '1 : product;

  // R7
  tail_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrElemEn != '1)) |-> (wrData == '1));

  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && vstartClr && !wrEn && !rdEn));
endmodule

// File: tb/gfm_group_mult_bench.sv
`timescale 1ns/1ps
module gfm_group_mult_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   sewCode = 3'd2;
  logic [7:0]   vl = '0, vstart = '0, totalElems = '0;
  logic         tailAgn = 1'b0;
  logic         busy, done, reject, vstartClr, rdEn, wrEn;
  logic [5:0]   rdIdx, wrIdx;
  logic [3:0]   wrElemEn;
  logic [127:0] rdY, rdH, wrData;

  logic [127:0] vdMem [64];
  logic [127:0] vsMem [64];

  always #2 clk = ~clk;

  assign rdY = vdMem[rdIdx];
  assign rdH = vsMem[rdIdx];

  gfm_group_mult u_gfm_group_mult (
    .clk(clk), .rstN(rstN), .start(start), .sewCode(sewCode), .vl(vl),
    .vstart(vstart), .tailAgn(tailAgn), .totalElems(totalElems),
    .busy(busy), .done(done), .reject(reject), .vstartClr(vstartClr),
    .rdEn(rdEn), .rdIdx(rdIdx), .rdY(rdY), .rdH(rdH), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrElemEn(wrElemEn), .wrData(wrData)
  );

  typedef struct {
    logic busy, done, clr, rej, rdEn, wrEn;
    logic [5:0] rdIdx, wrIdx;
    logic [3:0] mask;
    logic [127:0] data;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0, nBad = 0, cyc = 0;
  bit   chkOn = 1'b0;

  task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [127:0] brev(logic [127:0] x);
    logic [127:0] r;
    for (int b = 0; b < 16; b++)
      for (int i = 0; i < 8; i++) r[8*b+i] = x[8*b+7-i];
    return r;
  endfunction

  function automatic logic [127:0] gmulRef(logic [127:0] y, logic [127:0] h);
    logic [127:0] a, m, z;
    logic carry;
    a = brev(y); m = brev(h); z = '0;
    for (int j = 0; j < 128; j++) begin
      if (a[j]) z ^= m;
      carry = m[127];
      m = m << 1;
      if (carry) m[7:0] ^= 8'h87;
    end
    return brev(z);
  endfunction

  function automatic exp_t blank(string tag);
    exp_t e;
    e.busy = 0; e.done = 0; e.clr = 0; e.rej = 0; e.rdEn = 0; e.wrEn = 0;
    e.rdIdx = '0; e.wrIdx = '0; e.mask = '0; e.data = '0; e.tag = tag;
    return e;
  endfunction

  // behavioural expectation of every cycle of one operation
  task automatic plan(int sew, int vlv, int vst, bit ta, int tot);
    exp_t e;
    expQ.push_back(blank("R9"));
    if (sew != 2 || (vst % 4) != 0) begin
      e = blank("R1"); e.rej = 1; expQ.push_back(e);
      return;
    end
    for (int g = vst / 4; g < vlv / 4; g++) begin
      e = blank("R2"); e.busy = 1; e.rdEn = 1; e.rdIdx = 6'(g); expQ.push_back(e);
      for (int k = 0; k < 128; k++) begin
        e = blank("R2"); e.busy = 1; expQ.push_back(e);
      end
      e = blank("R3"); e.busy = 1; e.wrEn = 1; e.wrIdx = 6'(g); e.mask = 4'hF;
      e.data = gmulRef(vdMem[g], vsMem[g]); expQ.push_back(e);
    end
    e = blank("R6"); e.busy = 1; expQ.push_back(e);
    if (ta && vlv < tot) begin
      for (int g = vlv / 4; g < tot / 4; g++) begin
        e = blank("R7"); e.busy = 1; e.wrEn = 1; e.wrIdx = 6'(g); e.data = '1;
        for (int k = 0; k < 4; k++) e.mask[k] = (4*g + k) >= vlv;
        expQ.push_back(e);
      end
    end
    e = blank("R8"); e.busy = 1; e.done = 1; e.clr = 1; expQ.push_back(e);
  endtask

  // per-cycle comparison and register-file write model
  always @(negedge clk) begin
    exp_t e;
    if (chkOn) begin
      if (expQ.size() > 0) e = expQ.pop_front();
      else e = blank("R9");
      chk(busy == e.busy, "R8", "busy", 128'(busy), 128'(e.busy));
      chk(done == e.done, "R8", "done", 128'(done), 128'(e.done));
      chk(vstartClr == e.clr, "R8", "vstartClr", 128'(vstartClr), 128'(e.clr));
      chk(reject == e.rej, "R1", "reject", 128'(reject), 128'(e.rej));
      chk(rdEn == e.rdEn, "R2", "rdEn", 128'(rdEn), 128'(e.rdEn));
      if (e.rdEn) chk(rdIdx == e.rdIdx, "R2", "rdIdx", 128'(rdIdx), 128'(e.rdIdx));
      chk(wrEn == e.wrEn, e.tag, "wrEn", 128'(wrEn), 128'(e.wrEn));
      if (e.wrEn) begin
        chk(wrIdx == e.wrIdx, "R5", "wrIdx", 128'(wrIdx), 128'(e.wrIdx));
        chk(wrElemEn == e.mask, "R7", "wrElemEn", 128'(wrElemEn), 128'(e.mask));
        chk(wrData == e.data, e.tag, "wrData", wrData, e.data);
      end
      if (wrEn)
        for (int k = 0; k < 4; k++)
          if (wrElemEn[k]) vdMem[wrIdx][32*k +: 32] = wrData[32*k +: 32];
    end
  end

  task automatic run(int sew, int vlv, int vst, bit ta, int tot, bit poke);
    @(posedge clk); #1;
    sewCode = 3'(sew); vl = 8'(vlv); vstart = 8'(vst);
    tailAgn = ta; totalElems = 8'(tot); start = 1'b1;
    plan(sew, vlv, vst, ta, tot);
    @(posedge clk); #1 start = 1'b0;
    if (poke) begin
      // R9: second start mid-run with other operands
      repeat (20) @(posedge clk);
      #1 start = 1'b1; vl = 8'd40; vstart = 8'd0; tailAgn = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChecks++; nBad++;
      $display("FAIL R8 watchdog act=%0d exp=<150000", cyc);
      summary();
    end
  end

  initial begin
    logic [127:0] keep;
    for (int g = 0; g < 64; g++) begin
      vdMem[g] = {$urandom, $urandom, $urandom, $urandom};
      vsMem[g] = {$urandom, $urandom, $urandom, $urandom};
    end
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(!busy && !done && !vstartClr, "R8", "reset busy/done", 128'({busy, done}), 128'(0));
    chk(!rdEn && !wrEn && !reject, "R2", "reset strobes", 128'({rdEn, wrEn, reject}), 128'(0));
    chkOn = 1'b1;

    // R1 illegal element width, misaligned vstart
    run(3, 8, 0, 1'b1, 8, 1'b0);
    run(2, 8, 2, 1'b1, 8, 1'b0);

    // R3 identity: Y byte0 = 0x80 returns H
    vdMem[0] = 128'h80; keep = vsMem[0];
    run(2, 4, 0, 1'b0, 8, 1'b0);
    chk(vdMem[0] == keep, "R3", "identity product", vdMem[0], keep);

    // R3 reduction: single shift out of bit 127 folds to 0xE1
    vdMem[1] = 128'h40; vsMem[1] = 128'h1 << 120;
    run(2, 8, 4, 1'b0, 8, 1'b0);
    chk(vdMem[1] == 128'hE1, "R3", "reduction product", vdMem[1], 128'hE1);

    // R4 R5 R7 multi-group, equal operands in groups 0 and 2, tail fill, poke R9
    vdMem[2] = vdMem[0] ^ 128'h1234; vdMem[0] = vdMem[2]; vsMem[2] = vsMem[0];
    keep = vdMem[5];
    run(2, 16, 0, 1'b1, 24, 1'b1);
    chk(vdMem[0] == vdMem[2], "R4", "equal groups equal products", vdMem[2], vdMem[0]);
    chk(vdMem[4] == '1 && vdMem[5] == '1, "R7", "tail groups ones", vdMem[5], '1);

    // R7 partial tail: vl=10, elements 8 and 9 stay
    keep = vdMem[2];
    run(2, 10, 4, 1'b1, 16, 1'b0);
    chk(vdMem[2][63:0] == keep[63:0], "R7", "live elements below vl", 128'(vdMem[2][63:0]), 128'(keep[63:0]));
    chk(vdMem[2][127:64] == '1, "R7", "partial tail ones", 128'(vdMem[2][127:64]), 128'({64{1'b1}}));

    // R6 empty range with tail
    keep = vdMem[1];
    run(2, 6, 8, 1'b1, 8, 1'b0);
    chk(vdMem[1][63:0] == keep[63:0], "R6", "no product write", 128'(vdMem[1][63:0]), 128'(keep[63:0]));

    // R6 empty range, no tail
    run(2, 4, 4, 1'b0, 8, 1'b0);
    // R7 vl equals total, tail flag set
    run(2, 8, 4, 1'b1, 8, 1'b0);
    // R2 random groups, mid-range start
    run(2, 20, 12, 1'b0, 32, 1'b0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule